// File: doc/BRIEF.md
# Double-Buffered 10-bit PWM Generator

This block produces a single pulse-width-modulated output from an 8-bit period timer. Two low-order sub-count bits extend the timer into a 10-bit time base. With the smallest prescale they come from a free-running clock-phase counter. With larger prescales they are the top bits of the prescaler. Each period lasts (P+1)*4*N clock cycles, where P is the period register and N is the selected prescale ratio. The time base advances once every N clocks.

Software programs the period, the prescale and a 10-bit duty value through a small write port, and may do so at any moment. The duty value is written as an 8-bit upper part and a 2-bit lower part. It sits in a pending register and is copied into the active compare register only when a period completes. This keeps every period glitch-free. The output rises at the start of a period and falls when the 10-bit time base reaches the active duty value. A duty value of zero keeps the output low, and a duty value beyond the end of the period keeps it high.

Top module: `pwm_dbuf`

## Requirements
- R1: The duty value is 10 bits. A write to address 1 sets duty bits 9:2 from wrData[7:0]. A write to address 2 sets duty bits 1:0 from wrData[1:0].
- R2: A period lasts (P+1)*4*N clock cycles, where P is the value written to address 0. At each period end the timer and the sub-count both restart at time base zero.
- R3: A write to address 3 selects the prescale N from wrData[1:0]: 00 gives N=1, 01 gives N=4, and 10 or 11 give N=16. The time base advances once every N clocks.
- R4: In cycle c of a period (c counted from 0), pwmOut is 1 exactly when c < D*N, where D is the active duty value.
- R5: A duty write made during a period does not change that period's waveform. The new value governs the following period.
- R6: When D*N is at least the period length, pwmOut stays 1 for the whole period.
- R7: When D is 0, pwmOut stays 0 for the whole period. Clear wins over the set at the period start.
- R8: While enable is 0, pwmOut is 0 from the next cycle on and the timer is held at zero. After enable rises there is one load cycle, and then the first period starts using the pending duty value.
- R9: During and right after reset, pwmOut is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Runs the generator when 1 |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register select: 0 period, 1 duty high, 2 duty low, 3 prescale |
| wrData | input | 8 | Write data |
| pwmOut | output | 1 | PWM output |

## Verification
The bench builds the block with its default parameters: an 8-bit timer, two sub-count bits and a largest prescale of 16. With these values all three prescale ratios and both encodings of the largest ratio can be reached. Small period values keep even the divide-by-16 periods to a few hundred cycles. This leaves room to check duty values of zero, duty values inside the period, and duty values at or past the period end, at up to 1023. Each of these is compared cycle by cycle against the expected waveform, including a duty write that lands in the middle of a period.

// File: rtl/pwm_dbuf_pkg.sv
package pwm_dbuf_pkg;

  localparam int unsigned ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_PERIOD   = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_DUTY_HI  = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_DUTY_LO  = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_PRESCALE = 2'd3;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;   // copy pending duty to active and start a period
    logic idle;   // generator disabled
  } pwmStrobes_t;

  // Number of low fraction bits below the sub-count for a prescale select
  function automatic int unsigned prescaleShift(input logic [1:0] sel,
                                                input int unsigned maxShift);
    if (sel == 2'b00)      return 0;
    else if (sel == 2'b01) return maxShift / 2;
    else                   return maxShift;
  endfunction

endpackage

// File: rtl/pwm_dbuf_ctrl.sv
module pwm_dbuf_ctrl
  import pwm_dbuf_pkg::*;
#(
  parameter int unsigned TIMER_W   = 8,
  parameter int unsigned SUB_W     = 2,
  parameter int unsigned PSC_SHIFT = 4,
  localparam int unsigned TB_W     = TIMER_W + SUB_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               enable,
  input  logic               periodWe,
  input  logic               prescaleWe,
  input  logic [TIMER_W-1:0] wrData,
  output pwmStrobes_t        strobes,
  output logic [TB_W-1:0]    timeBase,
  output logic [TB_W-1:0]    tbNext
);

  localparam int unsigned FRAC_W = SUB_W + PSC_SHIFT;

  logic [TIMER_W-1:0] periodReg;
  logic [1:0]         pscSel;
  logic [TIMER_W-1:0] timer, timerNext;
  logic [FRAC_W-1:0]  frac, fracNext, fracLast;
  logic [FRAC_W-1:0]  fracShiftNow, fracShiftNext;
  logic               running, runNext;
  logic               tick, periodEnd, startRun;
  int unsigned        shiftAmt;

  // Configuration registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      periodReg <= '0;
      pscSel    <= 2'b00;
    end else begin
      if (periodWe)   periodReg <= wrData;
      if (prescaleWe) pscSel    <= wrData[1:0];
    end
  end

  // Next-state of the time base
  always_comb begin
    shiftAmt  = prescaleShift(pscSel, PSC_SHIFT);
    fracLast  = FRAC_W'((32'd1 << (SUB_W + shiftAmt)) - 32'd1);
    tick      = running && (frac == fracLast);
    periodEnd = tick && (timer >= periodReg);
    startRun  = enable && !running;

    runNext   = running;
    timerNext = timer;
    fracNext  = frac;
    if (!enable) begin
      runNext   = 1'b0;
      timerNext = '0;
      fracNext  = '0;
    end else if (startRun) begin
      runNext   = 1'b1;
      timerNext = '0;
      fracNext  = '0;
    end else if (periodEnd) begin
      timerNext = '0;
      fracNext  = '0;
    end else if (tick) begin
      timerNext = timer + TIMER_W'(1);
      fracNext  = '0;
    end else begin
      fracNext  = frac + FRAC_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running <= 1'b0;
      timer   <= '0;
      frac    <= '0;
    end else begin
      running <= runNext;
      timer   <= timerNext;
      frac    <= fracNext;
    end
  end

  // Sub-count is the top SUB_W bits of the active fraction span
  always_comb begin
    fracShiftNow  = frac >> shiftAmt;
    fracShiftNext = fracNext >> shiftAmt;
    timeBase      = {timer, fracShiftNow[SUB_W-1:0]};
    tbNext        = {timerNext, fracShiftNext[SUB_W-1:0]};
    strobes.load  = enable && (startRun || periodEnd);
    strobes.idle  = !enable;
  end

endmodule

// File: rtl/pwm_dbuf_datapath.sv
module pwm_dbuf_datapath
  import pwm_dbuf_pkg::*;
#(
  parameter int unsigned TIMER_W = 8,
  parameter int unsigned SUB_W   = 2,
  localparam int unsigned TB_W   = TIMER_W + SUB_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  pwmStrobes_t        strobes,
  input  logic               dutyHiWe,
  input  logic               dutyLoWe,
  input  logic [TIMER_W-1:0] wrData,
  input  logic [TB_W-1:0]    tbNext,
  output logic [TB_W-1:0]    dutyPending,
  output logic [TB_W-1:0]    dutyActive,
  output logic               pwmOut
);

  logic [TIMER_W-1:0] pendHi;
  logic [SUB_W-1:0]   pendLo;

  // Software-visible pending duty, writable at any time
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendHi <= '0;
      pendLo <= '0;
    end else begin
      if (dutyHiWe) pendHi <= wrData;
      if (dutyLoWe) pendLo <= wrData[SUB_W-1:0];
    end
  end

  assign dutyPending = {pendHi, pendLo};

  // Active duty, only reloaded at a period boundary
  always_ff @(posedge clk) begin
    if (!rstN)             dutyActive <= '0;
    else if (strobes.load) dutyActive <= dutyPending;
  end

  // Output: set at period start unless the new duty is zero (clear wins);
  // cleared on entering the cycle whose time base equals the active duty
  always_ff @(posedge clk) begin
    if (!rstN)                     pwmOut <= 1'b0;
    else if (strobes.idle)         pwmOut <= 1'b0;
    else if (strobes.load)         pwmOut <= (dutyPending != '0);
    else if (tbNext == dutyActive) pwmOut <= 1'b0;
  end

endmodule

// File: rtl/pwm_dbuf.sv
module pwm_dbuf
  import pwm_dbuf_pkg::*;
#(
  parameter int unsigned TIMER_W   = 8,
  parameter int unsigned SUB_W     = 2,
  parameter int unsigned PSC_SHIFT = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               enable,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [TIMER_W-1:0] wrData,
  output logic               pwmOut
);

  localparam int unsigned TB_W = TIMER_W + SUB_W;

  pwmStrobes_t     strobes;
  logic [TB_W-1:0] timeBase, tbNext, dutyPending, dutyActive;
  logic            periodWe, prescaleWe, dutyHiWe, dutyLoWe;

  assign periodWe   = wrEn && (wrAddr == ADDR_PERIOD);
  assign dutyHiWe   = wrEn && (wrAddr == ADDR_DUTY_HI);
  assign dutyLoWe   = wrEn && (wrAddr == ADDR_DUTY_LO);
  assign prescaleWe = wrEn && (wrAddr == ADDR_PRESCALE);

  pwm_dbuf_ctrl #(
    .TIMER_W(TIMER_W), .SUB_W(SUB_W), .PSC_SHIFT(PSC_SHIFT)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable),
    .periodWe(periodWe), .prescaleWe(prescaleWe), .wrData(wrData),
    .strobes(strobes), .timeBase(timeBase), .tbNext(tbNext)
  );

  pwm_dbuf_datapath #(
    .TIMER_W(TIMER_W), .SUB_W(SUB_W)
  ) u_datapath (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .dutyHiWe(dutyHiWe), .dutyLoWe(dutyLoWe), .wrData(wrData),
    .tbNext(tbNext), .dutyPending(dutyPending), .dutyActive(dutyActive),
    .pwmOut(pwmOut)
  );

endmodule

// File: rtl/pwm_dbuf_checker.sv
module pwm_dbuf_checker
  import pwm_dbuf_pkg::*;
#(
  parameter int unsigned TIMER_W = 8,
  parameter int unsigned SUB_W   = 2,
  localparam int unsigned TB_W   = TIMER_W + SUB_W
) (
  input logic            clk,
  input logic            rstN,
  input logic            enable,
  input logic            pwmOut,
  input pwmStrobes_t     strobes,
  input logic [TB_W-1:0] timeBase,
  input logic [TB_W-1:0] dutyPending,
  input logic [TB_W-1:0] dutyActive
);

  assert_idle_low_R8: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !pwmOut);

  assert_zero_duty_clear_wins_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.load && dutyPending == '0) |=> !pwmOut);

  assert_set_on_load_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.load && dutyPending != '0) |=> pwmOut);

  assert_no_rise_midperiod_R4: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.load |=> !$rose(pwmOut));

  assert_active_held_R5: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.load |=> $stable(dutyActive));

  assert_period_restart_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load |=> (timeBase == '0));

endmodule

bind pwm_dbuf pwm_dbuf_checker #(.TIMER_W(TIMER_W), .SUB_W(SUB_W)) u_checker (
  .clk(clk), .rstN(rstN), .enable(enable), .pwmOut(pwmOut),
  .strobes(strobes), .timeBase(timeBase),
  .dutyPending(dutyPending), .dutyActive(dutyActive)
);

// File: tb/pwm_dbuf_bench.sv
`timescale 1ns/1ps
module pwm_dbuf_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       enable = 1'b0;
  logic       wrEn = 1'b0;
  logic [1:0] wrAddr = 2'd0;
  logic [7:0] wrData = 8'd0;
  logic       pwmOut;

  always #2.5 clk = ~clk;

  pwm_dbuf u_pwm_dbuf (
    .clk(clk), .rstN(rstN), .enable(enable), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData), .pwmOut(pwmOut)
  );

  int    compared = 0;
  int    mismatched = 0;
  bit    finished = 0;
  bit    monOn = 0;
  logic  expQ[$];
  string tagQ[$];
  logic  mExp;
  string mTag;
  int    cyc = 0;

  // Monitor: pop one expected bit per cycle and compare
  always @(negedge clk) begin
    if (monOn && expQ.size() > 0) begin
      mExp = expQ.pop_front();
      mTag = tagQ.pop_front();
      compared++;
      if (pwmOut !== mExp) begin
        mismatched++;
        $display("FAIL %s cycle %0d: pwmOut actual=%b expected=%b", mTag, cyc, pwmOut, mExp);
      end
      cyc++;
    end
  end

  task automatic directCheck(input logic actual, input logic expected, input string tag);
    compared++;
    if (actual !== expected) begin
      mismatched++;
      $display("FAIL %s: pwmOut actual=%b expected=%b", tag, actual, expected);
    end
  endtask

  task automatic wrReg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // R1: high part to address 1, low two bits to address 2
  task automatic setDuty(input int d);
    wrReg(2'd1, 8'(d >> 2));
    wrReg(2'd2, 8'(d & 3));
  endtask

  // Driver: expected waveform of one period, from R2/R3/R4
  task automatic pushPeriod(input int p, input int sel, input int d, input string tag);
    int n, len;
    n = (sel == 0) ? 1 : (sel == 1) ? 4 : 16;
    len = (p + 1) * 4 * n;
    for (int c = 0; c < len; c++) begin
      expQ.push_back(c < d * n);
      tagQ.push_back(tag);
    end
  endtask

  task automatic startRun();
    cyc = 0;
    @(negedge clk);
    enable = 1'b1;
    @(posedge clk);          // load cycle (R8)
    monOn = 1'b1;
  endtask

  task automatic drainAndStop();
    while (expQ.size() != 0) @(posedge clk);
    monOn = 1'b0;
    @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    directCheck(pwmOut, 1'b0, "R8 low after disable");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    directCheck(pwmOut, 1'b0, "R9 during reset");
    rstN = 1'b1;
    @(negedge clk);
    directCheck(pwmOut, 1'b0, "R9 after reset");

    // R1/R4: divide-by-1, period 3, duty 6, two periods
    wrReg(2'd0, 8'd3);
    wrReg(2'd3, 8'd0);
    setDuty(6);
    repeat (3) @(negedge clk);
    directCheck(pwmOut, 1'b0, "R8 idle with duty pending");
    pushPeriod(3, 0, 6, "R4 div1 duty6 p1");
    pushPeriod(3, 0, 6, "R1 div1 duty6 p2");
    startRun();
    drainAndStop();

    // R3: divide-by-4, period 2, duty 5
    wrReg(2'd0, 8'd2);
    wrReg(2'd3, 8'd1);
    setDuty(5);
    pushPeriod(2, 1, 5, "R3 div4 duty5");
    startRun();
    drainAndStop();

    // R3: divide-by-16 with select 10, period 1, duty 3
    wrReg(2'd0, 8'd1);
    wrReg(2'd3, 8'd2);
    setDuty(3);
    pushPeriod(1, 2, 3, "R3 div16 sel2 duty3");
    startRun();
    drainAndStop();

    // R3: select 11 also divides by 16, period 0, duty 2
    wrReg(2'd0, 8'd0);
    wrReg(2'd3, 8'd3);
    setDuty(2);
    pushPeriod(0, 3, 2, "R3 div16 sel3 duty2");
    startRun();
    drainAndStop();

    // R5: mid-period write affects only the next period
    wrReg(2'd0, 8'd3);
    wrReg(2'd3, 8'd0);
    setDuty(4);
    pushPeriod(3, 0, 4, "R5 current period unchanged");
    pushPeriod(3, 0, 11, "R5 next period new duty");
    startRun();
    setDuty(11);
    drainAndStop();

    // R6: duty equal to and far past period length
    wrReg(2'd0, 8'd1);
    setDuty(8);
    pushPeriod(1, 0, 8, "R6 duty equals length");
    startRun();
    drainAndStop();
    setDuty(1023);
    pushPeriod(1, 0, 1023, "R6 duty max");
    startRun();
    drainAndStop();

    // R7: duty zero stays low, then R8 re-enable loads new pending value
    wrReg(2'd0, 8'd2);
    setDuty(0);
    pushPeriod(2, 0, 0, "R7 zero duty");
    pushPeriod(2, 0, 0, "R7 zero duty again");
    startRun();
    drainAndStop();
    setDuty(7);
    pushPeriod(2, 0, 7, "R8 first period uses pending");
    startRun();
    drainAndStop();

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule